// File: doc/BRIEF.md
# Autoreloading DMA Address Counter

This block generates the addresses for one DMA channel. It holds a live address and a count of the transfers left. Each time the FIFO side reports a finished transfer, the address moves up by one and the remaining count moves down by one. Software also loads a shadow start address and a shadow transfer count. When the live count runs out, both shadows are copied into the live registers on that same edge, so the next buffer follows the previous one with no gap.

Each reload raises a one-cycle interrupt pulse. This lets software refill the shadow registers for the buffer after next while the current buffer is being processed. All four registers can be written and read through a simple select, write-enable and data port. The block does not arbitrate between channels and does not implement a bus protocol.

Top module: `dmar_chan`

## Requirements
- R1: While rst_ni is low, and after it rises, the live address, shadow address, shadow count and live count all read zero, addr_o is zero and irq_o is low.
- R2: Register select encoding is 0 = live address, 1 = shadow address, 2 = shadow count, 3 = live count. A write with reg_we_i high updates the selected register at the clock edge. reg_rdata_o is combinational and returns the register chosen by reg_sel_i, zero-extended to 16 bits.
- R3: A transfer strobe while the live count is not 1 increments addr_o by one, wrapping from 0xFFFF to 0x0000, and decrements the live count by one.
- R4: A transfer strobe while the live count is 1 copies the shadow address into the live address and the shadow count into the live count on that same edge.
- R5: irq_o goes high for the one cycle that follows each reload edge. Reloads on consecutive edges give consecutive high cycles. At no other time is irq_o high.
- R6: A live count of 0 stands for 65536 transfers remaining, so a transfer decrements it to 0xFFFF. A shadow count of 0 therefore gives 65536 transfers between interrupts.
- R7: A software write to the live address or the live count takes priority over a concurrent increment, decrement or reload of that register. The other register still steps or reloads, and the interrupt still fires.
- R8: A write to the shadow address or shadow count on the same edge as a reload stores the new value, but the reload uses the value held before that edge.
- R9: With no transfer strobe and no write, all registers and addr_o hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write enable |
| reg_sel_i | input | 2 | Register select (see R2) |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Read data of the selected register |
| xfer_done_i | input | 1 | One-cycle strobe per completed transfer |
| addr_o | output | 16 | Address for the next transfer |
| irq_o | output | 1 | Reload interrupt pulse |

## Verification
Register writes, address steps and reloads appear on addr_o and reg_rdata_o one edge after the cycle in which their inputs are driven. irq_o is registered as well, so it is high in the cycle directly after the final transfer's edge. reg_rdata_o follows reg_sel_i with no clock delay. The bench drives every input on the falling edge and checks outputs just after the next falling edge, which is exactly one rising edge later. Read-back of a register is therefore checked in the same step that changed it. The 65536-transfer case is run out in full, and the bench counts every irq_o high cycle to confirm that no early pulse occurs.

// File: rtl/dmar_pkg.sv
package dmar_pkg;
  typedef enum logic [1:0] {
    SEL_CUR_ADDR = 2'd0,
    SEL_NXT_ADDR = 2'd1,
    SEL_RLD_CNT  = 2'd2,
    SEL_CUR_CNT  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/dmar_cnt_unit.sv
module dmar_cnt_unit #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_rld_i,
  input  logic          wr_cur_i,
  input  logic [CW-1:0] wdata_i,
  input  logic          step_i,
  output logic [CW-1:0] rld_cnt_o,
  output logic [CW-1:0] cur_cnt_o,
  output logic          last_o
);
  logic [CW-1:0] rld_q, cur_q, cur_d;

  // count of 0 means 2**CW remaining, so only 1 is the final transfer
  assign last_o = (cur_q == CW'(1));

  always_comb begin
    cur_d = cur_q;
    if (wr_cur_i)                cur_d = wdata_i;
    else if (step_i && last_o)   cur_d = rld_q;
    else if (step_i)             cur_d = cur_q - CW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rld_q <= '0;
      cur_q <= '0;
    end else begin
      cur_q <= cur_d;
      if (wr_rld_i) rld_q <= wdata_i;
    end
  end

  assign rld_cnt_o = rld_q;
  assign cur_cnt_o = cur_q;
endmodule

// File: rtl/dmar_addr_unit.sv
module dmar_addr_unit #(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_nxt_i,
  input  logic          wr_cur_i,
  input  logic [AW-1:0] wdata_i,
  input  logic          step_i,
  input  logic          reload_i,
  output logic [AW-1:0] nxt_addr_o,
  output logic [AW-1:0] cur_addr_o
);
  logic [AW-1:0] nxt_q, cur_q, cur_d;

  always_comb begin
    cur_d = cur_q;
    if (wr_cur_i)      cur_d = wdata_i;
    else if (reload_i) cur_d = nxt_q;
    else if (step_i)   cur_d = cur_q + AW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nxt_q <= '0;
      cur_q <= '0;
    end else begin
      cur_q <= cur_d;
      if (wr_nxt_i) nxt_q <= wdata_i;
    end
  end

  assign nxt_addr_o = nxt_q;
  assign cur_addr_o = cur_q;
endmodule

// File: rtl/dmar_chan.sv
module dmar_chan
  import dmar_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  localparam int DW = (AW > CW) ? AW : CW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [1:0]    reg_sel_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  input  logic          xfer_done_i,
  output logic [AW-1:0] addr_o,
  output logic          irq_o
);
  reg_sel_e      sel;
  logic          wr_cur_addr, wr_nxt_addr, wr_rld_cnt, wr_cur_cnt;
  logic          last, reload;
  logic [AW-1:0] cur_addr, nxt_addr;
  logic [CW-1:0] cur_cnt, rld_cnt;
  logic          irq_q;

  assign sel         = reg_sel_e'(reg_sel_i);
  assign wr_cur_addr = reg_we_i && (sel == SEL_CUR_ADDR);
  assign wr_nxt_addr = reg_we_i && (sel == SEL_NXT_ADDR);
  assign wr_rld_cnt  = reg_we_i && (sel == SEL_RLD_CNT);
  assign wr_cur_cnt  = reg_we_i && (sel == SEL_CUR_CNT);
  assign reload      = xfer_done_i && last;

  dmar_cnt_unit #(.CW(CW)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_rld_i  (wr_rld_cnt),
    .wr_cur_i  (wr_cur_cnt),
    .wdata_i   (reg_wdata_i[CW-1:0]),
    .step_i    (xfer_done_i),
    .rld_cnt_o (rld_cnt),
    .cur_cnt_o (cur_cnt),
    .last_o    (last)
  );

  dmar_addr_unit #(.AW(AW)) u_addr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_nxt_i   (wr_nxt_addr),
    .wr_cur_i   (wr_cur_addr),
    .wdata_i    (reg_wdata_i[AW-1:0]),
    .step_i     (xfer_done_i),
    .reload_i   (reload),
    .nxt_addr_o (nxt_addr),
    .cur_addr_o (cur_addr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= reload;
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (sel)
      SEL_CUR_ADDR: reg_rdata_o[AW-1:0] = cur_addr;
      SEL_NXT_ADDR: reg_rdata_o[AW-1:0] = nxt_addr;
      SEL_RLD_CNT:  reg_rdata_o[CW-1:0] = rld_cnt;
      SEL_CUR_CNT:  reg_rdata_o[CW-1:0] = cur_cnt;
      default:      reg_rdata_o = '0;
    endcase
  end

  assign addr_o = cur_addr;
  assign irq_o  = irq_q;
endmodule

// File: rtl/dmar_chan_chk.sv
module dmar_chan_chk #(
  parameter int AW = 16,
  parameter int CW = 16,
  localparam int DW = (AW > CW) ? AW : CW
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          reg_we_i,
  input logic [1:0]    reg_sel_i,
  input logic [DW-1:0] reg_wdata_i,
  input logic          xfer_done_i,
  input logic [AW-1:0] addr_o,
  input logic          irq_o,
  input logic [CW-1:0] cur_cnt_i,
  input logic [AW-1:0] nxt_addr_i
);
  logic wr_ca;
  logic fin;
  assign wr_ca = reg_we_i && (reg_sel_i == 2'd0);
  assign fin   = xfer_done_i && (cur_cnt_i == CW'(1));

  a_r3_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_done_i && !fin && !wr_ca) |=> (addr_o == $past(addr_o) + AW'(1)));

  a_r4_addr_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fin && !wr_ca) |=> (addr_o == $past(nxt_addr_i)));

  a_r5_irq_after_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin |=> irq_o);

  a_r5_irq_only_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fin) |=> !irq_o);

  a_r7_write_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ca |=> (addr_o == $past(reg_wdata_i[AW-1:0])));

  a_r9_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!xfer_done_i && !reg_we_i) |=> $stable(addr_o));
endmodule

bind dmar_chan dmar_chan_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_sel_i   (reg_sel_i),
  .reg_wdata_i (reg_wdata_i),
  .xfer_done_i (xfer_done_i),
  .addr_o      (addr_o),
  .irq_o       (irq_o),
  .cur_cnt_i   (cur_cnt),
  .nxt_addr_i  (nxt_addr)
);

// File: tb/dmar_chan_test.sv
module dmar_chan_test;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic        reg_we;
  logic [1:0]  reg_sel;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        xfer;
  logic [15:0] addr;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  dmar_chan uut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .reg_we_i    (reg_we),
    .reg_sel_i   (reg_sel),
    .reg_wdata_i (reg_wdata),
    .reg_rdata_o (reg_rdata),
    .xfer_done_i (xfer),
    .addr_o      (addr),
    .irq_o       (irq)
  );

  // {req, we, sel, wdata, xfer, exp_addr, exp_irq, exp_rdata}
  localparam int VN = 21;
  localparam logic [56:0] VEC [VN] = '{
    {4'd2, 1'b1, 2'd1, 16'h1000, 1'b0, 16'h0000, 1'b0, 16'h1000}, // R2 shadow addr
    {4'd2, 1'b1, 2'd2, 16'h0003, 1'b0, 16'h0000, 1'b0, 16'h0003}, // R2 shadow cnt
    {4'd2, 1'b1, 2'd0, 16'h00F0, 1'b0, 16'h00F0, 1'b0, 16'h00F0}, // R2 live addr
    {4'd2, 1'b1, 2'd3, 16'h0002, 1'b0, 16'h00F0, 1'b0, 16'h0002}, // R2 live cnt
    {4'd3, 1'b0, 2'd3, 16'h0000, 1'b1, 16'h00F1, 1'b0, 16'h0001}, // R3 step
    {4'd4, 1'b0, 2'd3, 16'h0000, 1'b1, 16'h1000, 1'b1, 16'h0003}, // R4 reload
    {4'd9, 1'b0, 2'd0, 16'h0000, 1'b0, 16'h1000, 1'b0, 16'h1000}, // R9 idle
    {4'd3, 1'b0, 2'd3, 16'h0000, 1'b1, 16'h1001, 1'b0, 16'h0002}, // R3
    {4'd3, 1'b0, 2'd3, 16'h0000, 1'b1, 16'h1002, 1'b0, 16'h0001}, // R3
    {4'd8, 1'b1, 2'd1, 16'h2000, 1'b1, 16'h1000, 1'b1, 16'h2000}, // R8 old shadow used
    {4'd7, 1'b1, 2'd0, 16'h0500, 1'b1, 16'h0500, 1'b0, 16'h0500}, // R7 write beats step
    {4'd3, 1'b0, 2'd3, 16'h0000, 1'b1, 16'h0501, 1'b0, 16'h0001}, // R3
    {4'd7, 1'b1, 2'd3, 16'h0005, 1'b1, 16'h2000, 1'b1, 16'h0005}, // R7 cnt write beats reload
    {4'd2, 1'b1, 2'd2, 16'h0001, 1'b0, 16'h2000, 1'b0, 16'h0001}, // R2
    {4'd2, 1'b1, 2'd3, 16'h0001, 1'b0, 16'h2000, 1'b0, 16'h0001}, // R2
    {4'd5, 1'b0, 2'd3, 16'h0000, 1'b1, 16'h2000, 1'b1, 16'h0001}, // R5 pulse
    {4'd5, 1'b0, 2'd3, 16'h0000, 1'b1, 16'h2000, 1'b1, 16'h0001}, // R5 back to back
    {4'd2, 1'b1, 2'd0, 16'hFFFF, 1'b0, 16'hFFFF, 1'b0, 16'hFFFF}, // R2
    {4'd2, 1'b1, 2'd3, 16'h0000, 1'b0, 16'hFFFF, 1'b0, 16'h0000}, // R2
    {4'd6, 1'b0, 2'd3, 16'h0000, 1'b1, 16'h0000, 1'b0, 16'hFFFF}, // R6 zero count, R3 wrap
    {4'd9, 1'b0, 2'd1, 16'h0000, 1'b0, 16'h0000, 1'b0, 16'h2000}  // R9
  };

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  task automatic cyc(input logic we, input logic [1:0] sel,
                     input logic [15:0] wd, input logic x);
    reg_we = we; reg_sel = sel; reg_wdata = wd; xfer = x;
    @(negedge clk);
    reg_we = 1'b0; xfer = 1'b0;
    #1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    int irq_cnt;
    rst_ni = 1'b0; reg_we = 1'b0; reg_sel = 2'd0; reg_wdata = '0; xfer = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1 reset state
    for (int s = 0; s < 4; s++) begin
      reg_sel = 2'(s); #1;
      chk("R1", "reset reg", reg_rdata, 16'h0000);
    end
    chk("R1", "reset addr", addr, 16'h0000);
    chk("R1", "reset irq", {15'd0, irq}, 16'h0000);

    @(negedge clk);
    for (int i = 0; i < VN; i++) begin
      logic [56:0] v;
      string rq;
      v = VEC[i];
      rq = $sformatf("R%0d", v[56:53]);
      cyc(v[52], v[51:50], v[49:34], v[33]);
      chk(rq, "addr", addr, v[32:17]);
      chk(rq, "irq", {15'd0, irq}, {15'd0, v[16]});
      chk(rq, "rdata", reg_rdata, v[15:0]);
    end

    // R6: shadow count 0 gives 65536 transfers between interrupts
    cyc(1'b1, 2'd2, 16'h0000, 1'b0);
    cyc(1'b1, 2'd1, 16'h0300, 1'b0);
    cyc(1'b1, 2'd3, 16'h0001, 1'b0);
    cyc(1'b0, 2'd3, 16'h0000, 1'b1);
    chk("R6", "first reload irq", {15'd0, irq}, 16'h0001);
    chk("R6", "loaded cnt", reg_rdata, 16'h0000);
    irq_cnt = 0;
    for (int k = 0; k < 65535; k++) begin
      cyc(1'b0, 2'd3, 16'h0000, 1'b1);
      if (irq) irq_cnt++;
    end
    chk("R6", "early irq count", 16'(irq_cnt), 16'h0000);
    chk("R6", "cnt before last", reg_rdata, 16'h0001);
    chk("R6", "addr before last", addr, 16'h02FF);
    cyc(1'b0, 2'd3, 16'h0000, 1'b1);
    chk("R6", "irq at 65536", {15'd0, irq}, 16'h0001);
    chk("R6", "addr reloaded", addr, 16'h0300);

    // R1 asynchronous reset mid-run
    #5 rst_ni = 1'b0;
    #2;
    for (int s = 0; s < 4; s++) begin
      reg_sel = 2'(s); #1;
      chk("R1", "async reset reg", reg_rdata, 16'h0000);
    end
    chk("R1", "async reset addr", addr, 16'h0000);
    chk("R1", "async reset irq", {15'd0, irq}, 16'h0000);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule